// File: doc/BRIEF.md
# Disk Controller DMA Request Handshake

This block is the peripheral side of the DMA handshake in a disk-interface controller. It raises a request line toward a DMA engine when a word can be moved. It accepts one bus command per request. It then withdraws the request after a fixed number of clocks, and that number depends on the transfer mode and direction. Two modes are supported: a multi-word mode and a faster Ultra DMA mode. Each mode works in both directions: the engine writing words into the controller, or reading words out of it.

An eight-entry, 16-bit FIFO sits between the bus side and the drive side. In the write direction, bus writes fill the FIFO and the drive side drains it. In the read direction, the drive side fills it and bus reads empty it. A word counter, loaded before a read transfer, limits how many words the engine may read.

All three data interfaces use valid/ready.
- Command port: a command transfers on a clock where `cmd_valid` and `cmd_ready` are both high. The master must hold the command stable while `cmd_ready` is low.
- Fill and drain ports: these move a word on a clock where their valid and ready are both high.
- Read data: it returns as a one-cycle `rd_valid` pulse and cannot be back-pressured.

`mode_udma` and `dir_rd` may change only while `xfer_en` has been low for at least two clocks.

Top module: `dma_req_handshake`

## Requirements
- R1: After reset, `dma_req`, `cmd_ready`, `rd_valid` and `fifo_full` are low and `fifo_empty` is high.
- R2: Multi-word write (`mode_udma`=0, `dir_rd`=0): the accepted word is in the FIFO (`fifo_empty` low) and `dma_req` is low in the clock after acceptance.
- R3: Multi-word read (`mode_udma`=0, `dir_rd`=1): `rd_valid` pulses with the oldest FIFO word in the clock after acceptance, and `dma_req` is low in that same clock.
- R4: Ultra DMA write (`mode_udma`=1, `dir_rd`=0): the word goes to a holding register in clock 1 after acceptance and into the FIFO, with FIFO status updated, in clock 2. `dma_req` stays high in clocks 1 and 2 and is low in clock 3.
- R5: Ultra DMA read (`mode_udma`=1, `dir_rd`=1): `rd_valid` pulses and `word_count` is decremented in clock 1 after acceptance. `dma_req` stays high in clock 1 and is low in clock 2.
- R6: From acceptance until `dma_req` has dropped, `cmd_ready` is low, so a command presented in that window is not taken.
- R7: `dma_req` rises only if `xfer_en` was high the clock before, and only with FIFO space (write) or FIFO data (read). It falls within two clocks of `xfer_en` going low.
- R8: The FIFO holds 8 words of 16 bits in arrival order. `fifo_full` and `fifo_empty` are never both high. `fill_ready` is high only in the read direction when not full, and `drain_valid` is high only in the write direction when not empty.
- R9: `cnt_load` sets `word_count` to `cnt_init`. Each accepted read decrements it. At zero, no read request is issued even if the FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_udma | input | 1 | 1 = Ultra DMA timing, 0 = multi-word timing |
| dir_rd | input | 1 | 1 = engine reads from controller, 0 = engine writes |
| xfer_en | input | 1 | Transfer enable; request can only rise while high |
| cnt_load | input | 1 | Load the word counter |
| cnt_init | input | CW | Value loaded into the word counter |
| word_count | output | CW | Remaining read words |
| cmd_valid | input | 1 | Bus command present |
| cmd_ready | output | 1 | Command can be accepted this clock |
| cmd_wdata | input | 16 | Write data of a bus write |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | 16 | Read data |
| fill_valid | input | 1 | Drive-side word to store (read direction) |
| fill_ready | output | 1 | FIFO can take a fill word |
| fill_data | input | 16 | Fill word |
| drain_valid | output | 1 | Word available to the drive side (write direction) |
| drain_ready | input | 1 | Drive side takes the word |
| drain_data | output | 16 | Oldest FIFO word |
| fifo_full | output | 1 | FIFO full flag |
| fifo_empty | output | 1 | FIFO empty flag |
| dma_req | output | 1 | DMA request to the engine |

## Verification
The bound checker watches every clock for these properties:
- the exact request drop cycle for each of the four mode and direction pairs;
- the blocking of `cmd_ready` after each acceptance;
- the enable, space and data gating of `cmd_ready`;
- the zero-count lockout;
- the exclusion between full and empty.

Some behaviour only the bench's scenarios can show:
- that the words arrive intact and in order through the FIFO and the holding register;
- that the FIFO status changes in the promised clock of an Ultra DMA write;
- that the request comes back once space is freed;
- that reads stop exactly at the loaded count while data is still buffered.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int unsigned WORD_W = 16;

  // Clocks from command acceptance to the first clock with the request low.
  function automatic logic [1:0] drop_latency(input logic udma, input logic rd);
    if (!udma)   return 2'd1;
    else if (rd) return 2'd2;
    else         return 2'd3;
  endfunction
endpackage

// File: rtl/dma_hs_fifo.sv
module dma_hs_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (fill == '0);
endmodule

// File: rtl/dma_hs_word_counter.sv
module dma_hs_word_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] init,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (load)            count <= init;
    else if (dec && !zero)    count <= count - 1'b1;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/dma_hs_req_seq.sv
module dma_hs_req_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] lat,
  input  logic       cond,
  output logic       req,
  output logic       busy
);
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      phase <= '0;
    end else if (accept) begin
      phase <= lat - 2'd1;
      if (lat == 2'd1) req <= 1'b0;
    end else if (phase != '0) begin
      phase <= phase - 2'd1;
      if (phase == 2'd1) req <= 1'b0;
    end else begin
      req <= cond;
    end
  end

  assign busy = (phase != '0);
endmodule

// File: rtl/dma_req_handshake.sv
module dma_req_handshake
  import dma_hs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_udma,
  input  logic              dir_rd,
  input  logic              xfer_en,
  input  logic              cnt_load,
  input  logic [CW-1:0]     cnt_init,
  output logic [CW-1:0]     word_count,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [WORD_W-1:0] fill_data,
  output logic              drain_valid,
  input  logic              drain_ready,
  output logic [WORD_W-1:0] drain_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              dma_req
);
  logic              busy, accept, cnt_zero, req_cond;
  logic              push, pop;
  logic [WORD_W-1:0] push_data, head;
  logic              hold_v;
  logic [WORD_W-1:0] hold_q;

  assign cmd_ready = dma_req && !busy;
  assign accept    = cmd_valid && cmd_ready;

  // Ultra DMA write: word parks one clock in the holding register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else begin
      hold_v <= accept && mode_udma && !dir_rd;
      if (accept && mode_udma && !dir_rd) hold_q <= cmd_wdata;
    end
  end

  assign fill_ready  = dir_rd && !fifo_full;
  assign drain_valid = !dir_rd && !fifo_empty;
  assign drain_data  = head;

  always_comb begin
    if (dir_rd) begin
      push      = fill_valid && fill_ready;
      push_data = fill_data;
      pop       = accept;
    end else begin
      push      = hold_v || (accept && !mode_udma);
      push_data = hold_v ? hold_q : cmd_wdata;
      pop       = drain_valid && drain_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && dir_rd;
      if (accept && dir_rd) rd_data <= head;
    end
  end

  assign req_cond = xfer_en && (dir_rd ? (!fifo_empty && !cnt_zero) : !fifo_full);

  dma_hs_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  dma_hs_word_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .init(cnt_init),
    .dec(accept && dir_rd), .count(word_count), .zero(cnt_zero)
  );

  dma_hs_req_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .lat(drop_latency(mode_udma, dir_rd)), .cond(req_cond),
    .req(dma_req), .busy(busy)
  );
endmodule

// File: rtl/dma_req_handshake_chk.sv
module dma_req_handshake_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_udma,
  input logic          dir_rd,
  input logic          xfer_en,
  input logic [CW-1:0] word_count,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rd_valid,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          dma_req
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_mw_wr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mode_udma && !dir_rd |=> !dma_req);

  p_mw_rd_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mode_udma && dir_rd |=> rd_valid && !dma_req);

  p_udma_wr_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_udma && !dir_rd |=> dma_req ##1 dma_req ##1 !dma_req);

  p_udma_rd_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_udma && dir_rd |=> rd_valid && dma_req ##1 !dma_req);

  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !cmd_ready);

  p_req_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(xfer_en));

  p_ready_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (dir_rd ? !fifo_empty : !fifo_full));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rd && (word_count == '0) |-> !cmd_ready);

  p_rd_valid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc && dir_rd));
endmodule

bind dma_req_handshake dma_req_handshake_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_udma(mode_udma), .dir_rd(dir_rd),
  .xfer_en(xfer_en), .word_count(word_count), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .rd_valid(rd_valid), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .dma_req(dma_req)
);

// File: tb/test_dma_req_handshake.sv
module test_dma_req_handshake;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_udma = 1'b0, dir_rd = 1'b0, xfer_en = 1'b0;
  logic          cnt_load = 1'b0;
  logic [CW-1:0] cnt_init = '0;
  logic [CW-1:0] word_count;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [15:0]   cmd_wdata = '0;
  logic          rd_valid;
  logic [15:0]   rd_data;
  logic          fill_valid = 1'b0, fill_ready;
  logic [15:0]   fill_data = '0;
  logic          drain_valid, drain_ready = 1'b0;
  logic [15:0]   drain_data;
  logic          fifo_full, fifo_empty, dma_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] sb [$];

  always #5 clk = ~clk;

  dma_req_handshake #(.DEPTH(8), .CW(CW)) i_dma_req_handshake (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compare every word leaving the block against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && (rd_valid || (drain_valid && drain_ready))) begin
      if (sb.size() == 0) chk("R8 unexpected word", 1, 0);
      else chk("R8 data order", rd_valid ? rd_data : drain_data, sb.pop_front());
    end
  end

  task automatic issue(input logic [15:0] d, input int lat, input bit rd, input string tag);
    bit pre_empty;
    int pre_cnt;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    pre_empty = fifo_empty;
    pre_cnt   = word_count;
    cmd_valid = 1'b1;
    cmd_wdata = d;
    if (!rd) sb.push_back(d);
    @(posedge clk);
    #1 cmd_wdata = 16'hDEAD;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      chk({tag, " req drop timing"}, dma_req, (k < lat) ? 1 : 0);
      chk("R6 ready blocked", cmd_ready, 0);
      if (rd && k == 1) begin
        chk({tag, " rd_valid"}, rd_valid, 1);
        chk({tag, " count"}, word_count, pre_cnt - 1);
      end
      if (!rd && lat == 1) chk("R2 fifo written", fifo_empty, 0);
      if (!rd && lat == 3 && pre_empty && k == 1) chk("R4 held not stored", fifo_empty, 1);
      if (!rd && lat == 3 && pre_empty && k == 2) chk("R4 stored", fifo_empty, 0);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic drain_all();
    @(posedge clk);
    #1 drain_ready = 1'b1;
    @(negedge clk);
    while (!fifo_empty) @(negedge clk);
    drain_ready = 1'b0;
  endtask

  task automatic fill(input logic [15:0] d);
    @(negedge clk);
    chk("R8 fill_ready", fill_ready, 1);
    @(posedge clk);
    #1 fill_valid = 1'b1; fill_data = d;
    sb.push_back(d);
    @(posedge clk);
    #1 fill_valid = 1'b0;
  endtask

  task automatic load_count(input int n);
    @(posedge clk);
    #1 cnt_load = 1'b1; cnt_init = CW'(n);
    @(posedge clk);
    #1 cnt_load = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 cmd_ready", cmd_ready, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 fifo_empty", fifo_empty, 1);
    chk("R1 fifo_full", fifo_full, 0);

    // Multi-word writes until the FIFO is full.
    @(posedge clk); #1 xfer_en = 1'b1;
    for (int i = 0; i < 8; i++) issue(16'h1000 + 16'(i * 17), 1, 0, "R2");
    wait_neg(4);
    chk("R7 full holds request low", dma_req, 0);
    chk("R8 full flag", fifo_full, 1);
    chk("R8 drain_valid", drain_valid, 1);
    drain_all();
    wait_neg(2);
    chk("R7 request back after space", dma_req, 1);
    @(posedge clk); #1 xfer_en = 1'b0;
    wait_neg(2);
    chk("R7 disable drops request", dma_req, 0);

    // Ultra DMA writes.
    @(posedge clk); #1 mode_udma = 1'b1;
    @(posedge clk); #1 xfer_en = 1'b1;
    for (int i = 0; i < 3; i++) issue(16'hA500 + 16'(i), 3, 0, "R4");
    @(posedge clk); #1 xfer_en = 1'b0;
    wait_neg(2);
    drain_all();
    chk("R8 write queue empty", sb.size(), 0);

    // Multi-word reads limited by the word counter.
    @(posedge clk); #1 mode_udma = 1'b0; dir_rd = 1'b1;
    wait_neg(2);
    chk("R8 drain_valid off in read", drain_valid, 0);
    load_count(3);
    for (int i = 0; i < 5; i++) fill(16'h5A00 + 16'(i * 3));
    @(posedge clk); #1 xfer_en = 1'b1;
    for (int i = 0; i < 3; i++) issue(16'h0, 1, 1, "R3");
    wait_neg(4);
    chk("R9 count at zero", word_count, 0);
    chk("R9 zero blocks request", dma_req, 0);
    chk("R9 data still buffered", fifo_empty, 0);

    // Ultra DMA reads of the remaining words.
    @(posedge clk); #1 xfer_en = 1'b0;
    wait_neg(2);
    @(posedge clk); #1 mode_udma = 1'b1;
    load_count(5);
    chk("R9 load", word_count, 5);
    @(posedge clk); #1 xfer_en = 1'b1;
    for (int i = 0; i < 2; i++) issue(16'h0, 2, 1, "R5");
    wait_neg(4);
    chk("R7 empty holds request low", dma_req, 0);
    chk("R5 fifo drained", fifo_empty, 1);
    chk("R5 count left", word_count, 3);
    chk("R8 read queue empty", sb.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule